// File: doc/BRIEF.md
# Iterative RC5-32/12 Encrypt/Decrypt Datapath

This block encrypts or decrypts one 64-bit block at a time with the RC5 cipher, using 32-bit words and 12 rounds. It follows a basic iterative architecture. A single pair of word registers holds the block in flight. One combinational round, shared by both directions, computes the next value of those registers, and a multiplexer in front of the registers picks between a freshly accepted block and the round result. Each clock performs one step of the cipher. A block takes one whitening step (the key add before encryption, or the key subtract after decryption) plus twelve rounds, so 13 busy cycles in total.

Round keys are not computed here. The block drives two key-word indices each busy cycle: the even index and the odd index of the current step. An external key store, already loaded by other logic, returns the two words combinationally in the same cycle. A caller offers a block with `in_valid`. The block takes it when `in_ready` is high, which happens only while no block is in flight. The direction is sampled from `enc_sel` at that moment. When the last step finishes, `out_valid` pulses for one cycle and `out_block` holds the result until the next block is taken.

Top module: `rc5_iter_core`

## Requirements
- R1: A synchronous reset, asserted at any time, leaves the unit idle in the cycle after it: `in_ready`=1, `out_valid`=0 and `out_block`=0.
- R2: A block is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the accepting edge until the edge that completes the block.
- R3: With `enc_sel`=1 at acceptance, the result is RC5 encryption. First A+=S[0] and B+=S[1]. Then for i=1..12, A=((A^B)<<<B)+S[2i] followed by B=((B^A)<<<A)+S[2i+1], using the new A. All sums are modulo 2^32.
- R4: With `enc_sel`=0 at acceptance, the result is RC5 decryption. For i=12 down to 1, B=((B-S[2i+1])>>>A)^A, then A=((A-S[2i])>>>B)^B, using the new B. After that, B-=S[1] and A-=S[0]. Decrypting an encrypted block returns the original block.
- R5: If a block is accepted at edge T, `out_valid` is 1 for exactly the one cycle that follows edge T+13. It is 0 in all other cycles.
- R6: In busy step s (s=0 for the first busy cycle), `key_idx_even` is 2c and `key_idx_odd` is 2c+1. Here c=s when encrypting and c=12-s when decrypting, so c counts 0..12 upward or 12..0 downward.
- R7: Every rotation amount is the low 5 bits of the controlling word. Words with upper bits set rotate by that amount modulo 32.
- R8: While a block is in flight, changes on `enc_sel`, `in_valid` and `in_block` have no effect on the result or on the timing.
- R9: While idle and not accepting, `out_block` keeps its last value.
- R10: Word A is `in_block[63:32]` and word B is `in_block[31:0]`. `out_block` is {A,B} in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_sel | input | 1 | 1 = encrypt, 0 = decrypt; sampled on acceptance |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Unit idle, block can be accepted |
| in_block | input | 64 | Input block {A,B} |
| out_valid | output | 1 | One-cycle pulse when a result is complete |
| out_block | output | 64 | Result block {A,B}, held while idle |
| key_idx_even | output | 5 | Index of the even round-key word for this step |
| key_idx_odd | output | 5 | Index of the odd round-key word for this step |
| key_even | input | 32 | Round-key word at `key_idx_even` |
| key_odd | input | 32 | Round-key word at `key_idx_odd` |

## Verification
The main function is tried with several kinds of block:
- An all-zero block, where every rotation amount starts at zero.
- An all-ones block and a block with the upper word bits set, which show whether rotation amounts are cut to five bits and whether words are rotated rather than shifted.
- Ordered byte patterns, which expose swapped halves or swapped key indices.
- Pseudo-random blocks in both directions.

Decrypting a block that the bench itself encrypted separates a correct inverse from a datapath that is only self-consistent. Holding `in_valid` high across completions, toggling `enc_sel` and offering junk while busy, and a reset in mid-block show whether the accept timing is right and whether the direction is captured once.

// File: rtl/rc5_iter_pkg.sv
package rc5_iter_pkg;

   typedef enum logic {
      DIR_DEC = 1'b0,
      DIR_ENC = 1'b1
   } rc5_dir_e;

   localparam int ROT_STAGED   = 0;
   localparam int ROT_SHIFT_OR = 1;

endpackage

// File: rtl/rc5_rotl.sv
module rc5_rotl #(
   parameter int W     = 32,
   parameter int STYLE = 0
) (
   input  logic [W-1:0]         din,
   input  logic [$clog2(W)-1:0] amt,
   output logic [W-1:0]         dout
);
   import rc5_iter_pkg::*;

   localparam int SH = $clog2(W);

   if ((1 << SH) != W) begin : g_bad_width
      $error("rc5_rotl: W must be a power of two");
   end
   if (STYLE != ROT_STAGED && STYLE != ROT_SHIFT_OR) begin : g_bad_style
      $error("rc5_rotl: unknown STYLE");
   end

   if (STYLE == ROT_STAGED) begin : g_staged
      logic [W-1:0] stg [0:SH];
      assign stg[0] = din;
      // largest stage first: W/2, W/4, ... 1
      for (genvar k = 0; k < SH; k++) begin : g_stage
         localparam int BI  = SH - 1 - k;
         localparam int SHF = 1 << BI;
         assign stg[k+1] = amt[BI] ? {stg[k][W-1-SHF:0], stg[k][W-1:W-SHF]}
                                   : stg[k];
      end
      assign dout = stg[SH];
   end else begin : g_shift_or
      logic [W-1:0] lo_part;
      logic [W-1:0] hi_part;
      assign hi_part = din << amt;
      assign lo_part = (amt == '0) ? '0 : (din >> (W - int'(amt)));
      assign dout    = hi_part | lo_part;
   end

   // a rotation neither creates nor loses set bits
   always_comb begin
      p_rot_ones_r7: assert ($countones(dout) == $countones(din))
         else $error("rotation changed bit population");
      if (amt == '0) begin
         p_rot_zero_r7: assert (dout == din)
            else $error("zero rotation altered the word");
      end
   end

endmodule

// File: rtl/rc5_round_dp.sv
module rc5_round_dp #(
   parameter int W         = 32,
   parameter int ROT_STYLE = 0
) (
   input  logic         enc,
   input  logic         whiten,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic [W-1:0] k_even,
   input  logic [W-1:0] k_odd,
   output logic [W-1:0] a_out,
   output logic [W-1:0] b_out
);
   localparam int SH = $clog2(W);

   logic [W-1:0]  x1, r1, first;
   logic [W-1:0]  x2, r2, second;
   logic [SH-1:0] amt1, amt2;
   logic [W-1:0]  a_wh, b_wh;

   // first half-round: encrypt updates A, decrypt updates B
   always_comb begin
      if (enc) begin
         x1   = a_in ^ b_in;
         amt1 = b_in[SH-1:0];
      end else begin
         x1   = b_in - k_odd;
         amt1 = '0 - a_in[SH-1:0];
      end
   end

   rc5_rotl #(.W(W), .STYLE(ROT_STYLE)) u_rot1 (
      .din (x1),
      .amt (amt1),
      .dout(r1)
   );

   assign first = enc ? (r1 + k_even) : (r1 ^ a_in);

   // second half-round consumes the freshly computed word
   always_comb begin
      if (enc) begin
         x2   = b_in ^ first;
         amt2 = first[SH-1:0];
      end else begin
         x2   = a_in - k_even;
         amt2 = '0 - first[SH-1:0];
      end
   end

   rc5_rotl #(.W(W), .STYLE(ROT_STYLE)) u_rot2 (
      .din (x2),
      .amt (amt2),
      .dout(r2)
   );

   assign second = enc ? (r2 + k_odd) : (r2 ^ first);

   assign a_wh = enc ? (a_in + k_even) : (a_in - k_even);
   assign b_wh = enc ? (b_in + k_odd)  : (b_in - k_odd);

   always_comb begin
      if (whiten) begin
         a_out = a_wh;
         b_out = b_wh;
      end else if (enc) begin
         a_out = first;
         b_out = second;
      end else begin
         a_out = second;
         b_out = first;
      end
   end

endmodule

// File: rtl/rc5_step_ctrl.sv
module rc5_step_ctrl #(
   parameter int ROUNDS = 12,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             dir_in,
   output logic             busy,
   output logic             enc,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   import rc5_iter_pkg::*;

   rc5_dir_e         dir_q;
   logic             busy_q;
   logic             done_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last;

   if ((1 << CNT_W) < ROUNDS + 1) begin : g_bad_cnt
      $error("rc5_step_ctrl: CNT_W too small for ROUNDS");
   end

   assign last = (dir_q == DIR_ENC) ? (cnt_q == CNT_W'(ROUNDS)) : (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         dir_q  <= DIR_ENC;
      end else begin
         done_q <= busy_q & last;
         if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
            end else if (dir_q == DIR_ENC) begin
               cnt_q <= cnt_q + 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end else if (start) begin
            busy_q <= 1'b1;
            dir_q  <= rc5_dir_e'(dir_in);
            cnt_q  <= dir_in ? '0 : CNT_W'(ROUNDS);
         end
      end
   end

   assign busy = busy_q;
   assign enc  = (dir_q == DIR_ENC);
   assign cnt  = cnt_q;
   assign done = done_q;

   p_count_up_r6: assert property (@(posedge clk) disable iff (rst)
      busy_q && dir_q == DIR_ENC && !last |=> cnt_q == $past(cnt_q) + 1'b1)
      else $error("round counter did not step up");

   p_count_down_r6: assert property (@(posedge clk) disable iff (rst)
      busy_q && dir_q == DIR_DEC && !last |=> cnt_q == $past(cnt_q) - 1'b1)
      else $error("round counter did not step down");

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q)
      else $error("completion flag held longer than one cycle");

   p_stay_busy_r2: assert property (@(posedge clk) disable iff (rst)
      busy_q && !last |=> busy_q)
      else $error("unit went idle before the last step");

   p_dir_stable_r8: assert property (@(posedge clk) disable iff (rst)
      busy_q && $past(busy_q) |-> $stable(dir_q))
      else $error("direction changed while busy");

endmodule

// File: rtl/rc5_iter_core.sv
module rc5_iter_core #(
   parameter int WORD_W    = 32,
   parameter int ROUNDS    = 12,
   parameter int ROT_STYLE = 0,
   localparam int BLK_W    = 2 * WORD_W,
   localparam int NKEYS    = 2 * ROUNDS + 2,
   localparam int KI_W     = $clog2(NKEYS),
   localparam int CNT_W    = $clog2(ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enc_sel,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [BLK_W-1:0] in_block,
   output logic             out_valid,
   output logic [BLK_W-1:0] out_block,
   output logic [KI_W-1:0]  key_idx_even,
   output logic [KI_W-1:0]  key_idx_odd,
   input  logic [WORD_W-1:0] key_even,
   input  logic [WORD_W-1:0] key_odd
);
   if (WORD_W != 16 && WORD_W != 32 && WORD_W != 64) begin : g_bad_word
      $error("rc5_iter_core: WORD_W must be 16, 32 or 64");
   end
   if (ROUNDS < 1) begin : g_bad_rounds
      $error("rc5_iter_core: ROUNDS must be at least 1");
   end

   logic              busy, enc, done, accept;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] a_q, b_q, a_nxt, b_nxt;

   assign in_ready = ~busy;
   assign accept   = in_valid & ~busy;

   rc5_step_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .start (accept),
      .dir_in(enc_sel),
      .busy  (busy),
      .enc   (enc),
      .cnt   (cnt),
      .done  (done)
   );

   // step c uses key words 2c and 2c+1; c = 0 is the whitening step
   assign key_idx_even = KI_W'({cnt, 1'b0});
   assign key_idx_odd  = KI_W'({cnt, 1'b1});

   rc5_round_dp #(.W(WORD_W), .ROT_STYLE(ROT_STYLE)) u_round (
      .enc   (enc),
      .whiten(cnt == '0),
      .a_in  (a_q),
      .b_in  (b_q),
      .k_even(key_even),
      .k_odd (key_odd),
      .a_out (a_nxt),
      .b_out (b_nxt)
   );

   // input multiplexer in front of the single state register
   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else if (busy) begin
         a_q <= a_nxt;
         b_q <= b_nxt;
      end else if (accept) begin
         a_q <= in_block[BLK_W-1:WORD_W];
         b_q <= in_block[WORD_W-1:0];
      end
   end

   assign out_block = {a_q, b_q};
   assign out_valid = done;

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !busy && !accept |=> $stable(out_block))
      else $error("result changed while idle");

   p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
      busy |-> key_idx_odd < KI_W'(NKEYS))
      else $error("key index beyond the key store");

   p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> in_ready)
      else $error("result flagged while not idle");

   p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
      accept |=> !in_ready)
      else $error("unit still ready after accepting");

endmodule

// File: tb/rc5_iter_core_tb.sv
`timescale 1ns/1ps
module rc5_iter_core_tb;
   localparam int NR = 12;
   localparam int NK = 2 * NR + 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        enc_sel = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] in_block = '0;
   logic        in_ready, out_valid;
   logic [63:0] out_block;
   logic [4:0]  key_idx_even, key_idx_odd;
   logic [31:0] key_even, key_odd;

   logic [31:0] skey [0:NK-1];

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   assign key_even = (key_idx_even < NK) ? skey[key_idx_even] : 32'h0;
   assign key_odd  = (key_idx_odd  < NK) ? skey[key_idx_odd]  : 32'h0;

   rc5_iter_core u_dut (
      .clk(clk), .rst(rst), .enc_sel(enc_sel), .in_valid(in_valid),
      .in_ready(in_ready), .in_block(in_block), .out_valid(out_valid),
      .out_block(out_block), .key_idx_even(key_idx_even),
      .key_idx_odd(key_idx_odd), .key_even(key_even), .key_odd(key_odd)
   );

   function automatic logic [31:0] rl(logic [31:0] x, int n);
      int m = n % 32;
      if (m == 0) return x;
      return (x << m) | (x >> (32 - m));
   endfunction

   function automatic logic [31:0] rr(logic [31:0] x, int n);
      return rl(x, (32 - (n % 32)) % 32);
   endfunction

   function automatic logic [63:0] ref_enc(logic [63:0] blk);
      logic [31:0] a = blk[63:32] + skey[0];
      logic [31:0] b = blk[31:0] + skey[1];
      for (int i = 1; i <= NR; i++) begin
         a = rl(a ^ b, int'(b[4:0])) + skey[2*i];
         b = rl(b ^ a, int'(a[4:0])) + skey[2*i+1];
      end
      return {a, b};
   endfunction

   function automatic logic [63:0] ref_dec(logic [63:0] blk);
      logic [31:0] a = blk[63:32];
      logic [31:0] b = blk[31:0];
      for (int i = NR; i >= 1; i--) begin
         b = rr(b - skey[2*i+1], int'(a[4:0])) ^ a;
         a = rr(a - skey[2*i], int'(b[4:0])) ^ b;
      end
      return {a - skey[0], b - skey[1]};
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-level reference model
   logic        m_busy = 1'b0, m_valid = 1'b0, m_enc = 1'b1, m_after_rst = 1'b1;
   int          m_step = 0;
   logic [63:0] m_res = '0, m_last = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_busy <= 1'b0; m_valid <= 1'b0; m_step <= 0;
         m_last <= '0; m_after_rst <= 1'b1;
      end else begin
         m_after_rst <= 1'b0;
         m_valid <= 1'b0;
         if (m_busy) begin
            if (m_step == NR) begin
               m_busy <= 1'b0; m_valid <= 1'b1; m_last <= m_res;
            end else begin
               m_step <= m_step + 1;
            end
         end else if (in_valid) begin
            m_busy <= 1'b1; m_step <= 0; m_enc <= enc_sel;
            m_res  <= enc_sel ? ref_enc(in_block) : ref_dec(in_block);
         end
      end
   end

   bit stop_cmp = 1'b0;

   always @(negedge clk) begin
      if (!rst && !stop_cmp) begin
         int c;
         chk(m_after_rst ? "R1 in_ready" : "R2 in_ready", 64'(in_ready), 64'(!m_busy));
         chk(m_after_rst ? "R1 out_valid" : "R5 out_valid", 64'(out_valid), 64'(m_valid));
         if (!m_busy)
            chk(m_after_rst ? "R1 out_block" :
                m_valid ? (m_enc ? "R3 R10 result" : "R4 R10 result") : "R9 hold",
                out_block, m_last);
         if (m_busy) begin
            c = m_enc ? m_step : NR - m_step;
            chk("R6 key indices", {54'd0, key_idx_even, key_idx_odd},
                {54'd0, 5'(2*c), 5'(2*c+1)});
         end
      end
   end

   task automatic send(logic [63:0] blk, logic dir);
      while (!in_ready) @(negedge clk);
      in_block = blk; enc_sel = dir; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!in_ready) @(negedge clk);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [63:0] ct, pt;
      for (int i = 0; i < NK; i++)
         skey[i] = (32'(i) * 32'h9E3779B9) ^ rl(32'hB7E15163, i);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R3 R10: fixed patterns in the encrypt direction
      send(64'h0, 1'b1);                 wait_idle(); @(negedge clk);
      send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1); wait_idle(); @(negedge clk);
      chk("R7 all-ones encrypt", out_block, ref_enc(64'hFFFF_FFFF_FFFF_FFFF));
      send(64'h0123_4567_89AB_CDEF, 1'b1); wait_idle(); @(negedge clk);
      ct = out_block;
      chk("R10 ordered pattern", ct, ref_enc(64'h0123_4567_89AB_CDEF));

      // R4: inverse of a bench-computed ciphertext
      send(ct, 1'b0); wait_idle(); @(negedge clk);
      chk("R4 roundtrip", out_block, 64'h0123_4567_89AB_CDEF);
      send(64'hDEAD_BEEF_CAFE_F00D, 1'b0); wait_idle(); @(negedge clk);

      // R7: high word bits set, rotation must use only the low five
      send(64'hFFFF_FFE3_8000_003F, 1'b1); wait_idle(); @(negedge clk);
      chk("R7 high bits", out_block, ref_enc(64'hFFFF_FFE3_8000_003F));

      // R8: direction and data changes while busy are ignored
      pt = 64'h1357_9BDF_2468_ACE0;
      send(pt, 1'b1);
      for (int k = 0; k < 8; k++) begin
         enc_sel = k[0]; in_valid = k[1]; in_block = {32'(k), 32'hA5A5_5A5A};
         @(negedge clk);
      end
      in_valid = 1'b0;
      wait_idle(); @(negedge clk);
      chk("R8 ignored while busy", out_block, ref_enc(pt));

      // R2 R5: in_valid held high across completions
      in_block = 64'h0F0F_F0F0_3C3C_C3C3; enc_sel = 1'b0; in_valid = 1'b1;
      repeat (45) @(negedge clk);
      in_valid = 1'b0;
      wait_idle(); @(negedge clk);

      // R1: reset in the middle of a block
      send(64'h5555_AAAA_1234_8765, 1'b1);
      repeat (5) @(negedge clk);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      @(negedge clk);

      // random blocks in both directions, with roundtrip checks
      for (int n = 0; n < 40; n++) begin
         pt = {$urandom(), $urandom()};
         send(pt, n[0]); wait_idle(); @(negedge clk);
         if (n[0]) begin
            ct = out_block;
            send(ct, 1'b0); wait_idle(); @(negedge clk);
            chk("R4 random roundtrip", out_block, pt);
         end
      end

      repeat (3) @(negedge clk);
      stop_cmp = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule